// File: doc/BRIEF.md
# Byte/Word Working Register Store

This block is the storage side of a 16-bit controller datapath. It holds a bank of 32 working words and one accumulator word. The datapath reads a bank entry through a registered output stage and sees the accumulator value directly. Each cycle the instruction decoder provides four things: a global active-low instruction enable, a two-bit destination code that says which store the current instruction targets, a byte/word mode bit, and the word to write.

A store changes only when both qualifiers agree: the enable is low and the destination code names that store. In byte mode only the low eight bits of the target change and the high eight bits keep their value. A read and a write share one address. When both go to the same entry in one cycle, the read returns the value the entry held before that cycle's write. After reset the accumulator is zero and the bank contents are unknown.

Top module: `wreg_store`

## Requirements
- R1: The bank has 32 entries of 16 bits, selected by the 5-bit `addr` for both reading and writing. A word written to an entry is returned for that entry until the entry is written again.
- R2: A bank entry is written on the rising clock edge only when `ien_n` = 0 and `dst_sel` = 2'b01. It is written with `wdata`, or with the masked form of it that R5 describes.
- R3: While `ien_n` = 1, neither the bank nor the accumulator changes, whatever the value of `dst_sel`.
- R4: The accumulator loads on the rising clock edge only when `ien_n` = 0 and `dst_sel` = 2'b10. At all other times it keeps its value.
- R5: When `byte_mode` = 1, a write changes only bits 7:0 of the target (bank entry or accumulator), and bits 15:8 keep their value. When `byte_mode` = 0, all 16 bits are written.
- R6: `rdata` is registered. After each rising edge it shows the content that entry `addr` held just before that edge, and it keeps that value until the next edge.
- R7: When a bank write and a read go to the same address in one cycle, `rdata` returns the old content of the entry. The new content shows from the next read onward.
- R8: The reset `rst_n` is synchronous and active low. It clears the accumulator to zero, and no write takes place while it is low.
- R9: The destination codes 2'b00 and 2'b11 write nothing, even when `ien_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_n | input | 1 | Active-low instruction enable |
| dst_sel | input | 2 | Destination: 01 bank, 10 accumulator, 00/11 none |
| byte_mode | input | 1 | 1 = write low byte only, 0 = write full word |
| addr | input | 5 | Bank entry for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered bank read data |
| acc | output | 16 | Accumulator value |

## Verification
The two functions that can fall in the same cycle are a bank write and the registered read of that same entry. The random phase uses a narrow address range, so writes and reads often hit the same entry. A directed sequence also writes one entry in word mode and then in byte mode while reading it. The bench judges each such cycle against a model that captures the read value before it applies the write. It then confirms on the next cycle that the new value, with its upper byte kept or replaced as the mode requires, has arrived.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
   typedef enum logic [1:0] {
      DST_NONE  = 2'b00,
      DST_ARRAY = 2'b01,
      DST_ACC   = 2'b10,
      DST_RSVD  = 2'b11
   } dst_e;
endpackage

// File: rtl/wreg_lane_merge.sv
// Builds the value to store: the full new word, or only the low lane with
// the upper part taken from the current content.
module wreg_lane_merge #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] nw,
   output logic [DATA_W-1:0] merged
);
   initial begin
      if (BYTE_W < 1 || BYTE_W > DATA_W) $error("wreg_lane_merge: BYTE_W out of range");
   end

   generate
      if (BYTE_W < DATA_W) begin : g_split
         assign merged[BYTE_W-1:0]      = nw[BYTE_W-1:0];
         assign merged[DATA_W-1:BYTE_W] = byte_mode ? cur[DATA_W-1:BYTE_W]
                                                    : nw[DATA_W-1:BYTE_W];
      end else begin : g_full
         logic unused_ok;
         assign unused_ok = byte_mode ^ (^cur);
         assign merged    = nw;
      end
   endgenerate
endmodule

// File: rtl/wreg_array.sv
module wreg_array
   import wreg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 32,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              byte_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_comb
);
   initial begin
      if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) $error("wreg_array: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] wr_word;

   assign rd_comb = mem[addr];

   wreg_lane_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_merge (
      .byte_mode (byte_mode),
      .cur       (rd_comb),
      .nw        (wdata),
      .merged    (wr_word)
   );

   always_ff @(posedge clk) begin
      if (rst_n && wr_en) mem[addr] <= wr_word;
   end

   // R2 / R3 / R9: without a qualified write the addressed entry keeps its value
   a_r2_array_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> mem[$past(addr)] == $past(mem[addr]));

   // R5: byte write leaves the upper lane of the entry untouched
   a_r5_array_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && byte_mode) |=> mem[$past(addr)][DATA_W-1:BYTE_W] == $past(mem[addr][DATA_W-1:BYTE_W]));
endmodule

// File: rtl/wreg_acc.sv
module wreg_acc #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] acc_q
);
   logic [DATA_W-1:0] ld_word;

   wreg_lane_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_merge (
      .byte_mode (byte_mode),
      .cur       (acc_q),
      .nw        (wdata),
      .merged    (ld_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (ld_en) acc_q <= ld_word;
   end

   // R4: no load request means the accumulator holds
   a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(acc_q));

   // R4 / R5: a word-mode load takes the full input word
   a_r4_acc_word_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !byte_mode) |=> acc_q == $past(wdata));

   // R5: a byte-mode load keeps the upper lane
   a_r5_acc_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && byte_mode) |=> acc_q[DATA_W-1:BYTE_W] == $past(acc_q[DATA_W-1:BYTE_W]));
endmodule

// File: rtl/wreg_hold.sv
module wreg_hold #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) q <= d;
endmodule

// File: rtl/wreg_store.sv
module wreg_store
   import wreg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 32,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien_n,
   input  logic [1:0]        dst_sel,
   input  logic              byte_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] acc
);
   dst_e              dst;
   logic              arr_wr;
   logic              acc_ld;
   logic [DATA_W-1:0] arr_rd;

   assign dst    = dst_e'(dst_sel);
   assign arr_wr = !ien_n && (dst == DST_ARRAY);
   assign acc_ld = !ien_n && (dst == DST_ACC);

   wreg_array #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (arr_wr),
      .byte_mode (byte_mode),
      .addr      (addr),
      .wdata     (wdata),
      .rd_comb   (arr_rd)
   );

   wreg_hold #(.DATA_W(DATA_W)) u_hold (
      .clk (clk),
      .d   (arr_rd),
      .q   (rdata)
   );

   wreg_acc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (acc_ld),
      .byte_mode (byte_mode),
      .wdata     (wdata),
      .acc_q     (acc)
   );

   // R7: the read during a write returns the content from before the write
   a_r7_read_old: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr |=> rdata == $past(arr_rd));

   // R3: a disabled instruction leaves the accumulator alone
   a_r3_acc_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      ien_n |=> $stable(acc));

   // R9: reserved and empty destination codes never load the accumulator
   a_r9_no_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_sel == 2'b00 || dst_sel == 2'b11) |=> $stable(acc));
endmodule

// File: tb/sim_wreg_store.sv
module sim_wreg_store;
   localparam int CLK_PS = 4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ien_n = 1'b1;
   logic [1:0]  dst_sel = 2'b00;
   logic        byte_mode = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [15:0] acc;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;

   logic [15:0] m_mem [32];
   bit          m_ok  [32];
   logic [15:0] m_acc;
   logic [15:0] exp_rd;
   bit          exp_rd_ok;

   always #(CLK_PS/2) clk = ~clk;

   wreg_store u0 (
      .clk(clk), .rst_n(rst_n), .ien_n(ien_n), .dst_sel(dst_sel),
      .byte_mode(byte_mode), .addr(addr), .wdata(wdata),
      .rdata(rdata), .acc(acc)
   );

   function automatic logic [15:0] merge(logic [15:0] cur, logic [15:0] nw, bit bm);
      return bm ? {cur[15:8], nw[7:0]} : nw;
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // Drive one cycle, update the model, then compare after the edge.
   task automatic step(bit rst, bit en_n, logic [1:0] d, bit bm,
                       logic [4:0] a, logic [15:0] w, string req);
      rst_n = !rst; ien_n = en_n; dst_sel = d; byte_mode = bm; addr = a; wdata = w;
      exp_rd    = m_mem[a];
      exp_rd_ok = m_ok[a];
      if (rst) m_acc = '0;
      else if (!en_n && d == 2'b01) begin
         if (bm && !m_ok[a]) m_ok[a] = 1'b0;
         else begin m_mem[a] = merge(m_mem[a], w, bm); m_ok[a] = 1'b1; end
      end else if (!en_n && d == 2'b10) m_acc = merge(m_acc, w, bm);
      @(negedge clk);
      check({req, " acc"}, acc, m_acc);
      if (exp_rd_ok) check({req, " rdata"}, rdata, exp_rd);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin m_mem[i] = '0; m_ok[i] = 1'b0; end
      m_acc = '0;
      @(negedge clk);
      step(1, 0, 2'b10, 0, 5'd0, 16'hFFFF, "R8 reset");
      step(1, 1, 2'b00, 0, 5'd0, 16'h0000, "R8 reset");
      check("R8 acc zero after reset", acc, 16'h0000);

      // R1: fill every entry in word mode, then read each back
      for (int i = 0; i < 32; i++) step(0, 0, 2'b01, 0, 5'(i), 16'(16'hA500 ^ (i * 16'h0111)), "R1 fill");
      for (int i = 0; i < 32; i++) step(0, 1, 2'b00, 0, 5'(i), 16'h0, "R1 readback");

      // R3: enable high blocks writes to both stores
      step(0, 1, 2'b01, 0, 5'd3, 16'hDEAD, "R3 array blocked");
      step(0, 1, 2'b10, 0, 5'd3, 16'hDEAD, "R3 acc blocked");
      step(0, 1, 2'b00, 0, 5'd3, 16'h0, "R3 readback");

      // R9: no-destination codes write nothing
      step(0, 0, 2'b00, 0, 5'd4, 16'h1111, "R9 code 00");
      step(0, 0, 2'b11, 0, 5'd4, 16'h2222, "R9 code 11");
      step(0, 1, 2'b00, 0, 5'd4, 16'h0, "R9 readback");

      // R4/R5: accumulator word then byte load
      step(0, 0, 2'b10, 0, 5'd0, 16'h1234, "R4 acc word");
      step(0, 0, 2'b10, 1, 5'd0, 16'hABCD, "R5 acc byte");
      check("R5 acc upper kept", acc, 16'h12CD);

      // R7/R5: same-address write and read, word then byte
      step(0, 0, 2'b01, 0, 5'd9, 16'h5A5A, "R7 raw word");
      step(0, 0, 2'b01, 1, 5'd9, 16'hFF00, "R7 raw byte");
      step(0, 1, 2'b00, 0, 5'd9, 16'h0, "R5 array byte result");
      check("R5 array upper kept", rdata, 16'h5A00);

      // R6: rdata holds across cycles with the same address
      step(0, 1, 2'b00, 0, 5'd9, 16'h0, "R6 hold");

      // random phase over a narrow address window
      void'($urandom(32'd1977));
      for (int k = 0; k < 4000; k++) begin
         logic [15:0] r;
         r = 16'($urandom);
         step(($urandom % 64) == 0, ($urandom % 4) == 0, 2'($urandom), r[0],
              5'($urandom % 6), 16'($urandom), "R2 R4 R5 R7 random");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PS * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule